// File: doc/BRIEF.md
# DMA Channel Command Controller

This block is the command and status front end of one DMA channel. It serves equally as a transfer channel or an event channel. Software writes a command code into one byte of a combined control/status word. The block moves through five channel states and shows the current one in a read-only byte of the same word. The surrounding datapath follows the `chan_active` output to decide whether it may take new work. In return it reports, every cycle, whether work is pending, whether it is idle and whether it has hit an error.

A suspend request is graceful. The channel stops offering new work at once. It keeps its operational state until the datapath reports idle, and only then shows the suspended state. A reset request returns the channel to disabled from any state, including the error-stopped state, and raises a one-cycle pulse that clears the channel's ring pointers elsewhere.

Top module: `chan_cmd_ctrl`

## Requirements
- R1: After `rst_n` is released, `csr_rdata` is all zero (state disabled = 0, command read-back 0), and `chan_active` and `ptr_clr` are low.
- R2: A write with `csr_we` high takes its command from `csr_wdata[23:16]`. `csr_rdata[15:8]` shows the state, zero-extended from codes disabled = 0, enabled = 1, running = 2, suspended = 3, stopped = 4. `csr_rdata[23:16]` shows the last defined command written, and every other read bit is zero. The state and the read-back both change at the clock edge that samples the write.
- R3: Command code 1 (enable) moves a disabled or suspended channel to enabled. `chan_active` is high exactly when the state is enabled or running and no suspend is draining.
- R4: An enabled channel goes to running at an edge where `work_pend` is high. A running channel goes back to enabled at an edge where `work_pend` is low and `dp_idle` is high.
- R5: Command code 2 (suspend) on an enabled or running channel gives suspended at once if `dp_idle` is high at that edge. Otherwise it starts a drain: `chan_active` drops, the state is held, and the channel becomes suspended at the first later edge with `dp_idle` high. Suspend on a disabled or suspended channel has no effect on the state.
- R6: An enable command during a drain cancels it, and `chan_active` returns high.
- R7: Command code 0 (disable) moves any state other than stopped to disabled and cancels a drain.
- R8: `dp_err` high at an edge while the channel is running gives stopped. The stopped state ignores every input except the reset command.
- R9: Command code 9 (reset) gives disabled from any state. In the cycle after that edge, `ptr_clr` is high for one cycle.
- R10: A write of any other command code changes neither the command read-back nor the state. Only the datapath inputs still act on the state.
- R11: A defined command beats the datapath transitions at the same edge. The one exception is `dp_err` on a running channel, which beats every command except reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 32 | Write data; the command byte is bits 23:16 |
| csr_rdata | output | 32 | Read data; the state is in bits 15:8, the command read-back in bits 23:16 |
| work_pend | input | 1 | Datapath has work queued |
| dp_idle | input | 1 | Datapath has nothing in flight |
| dp_err | input | 1 | Datapath error |
| chan_active | output | 1 | Channel may accept new work |
| ptr_clr | output | 1 | One-cycle pointer clear after a reset command |

## Verification
A wrong state value shows in `csr_rdata[15:8]` in the cycle right after the edge that caused it, and `chan_active` diverges in the same cycle. A lost or stuck drain flag is the subtle case. It is visible only through `chan_active` while the state byte still reads enabled or running, so every sampled cycle compares `chan_active` as well as the state. Random traffic mixes commands with `dp_idle` low, so drains stay open across several cycles. A broken pointer-clear pulse shows one cycle after a reset write.

// File: rtl/chcmd_pkg.sv
package chcmd_pkg;

   // command codes written into the command byte
   localparam int unsigned CMD_DISABLE = 0;
   localparam int unsigned CMD_ENABLE  = 1;
   localparam int unsigned CMD_SUSPEND = 2;
   localparam int unsigned CMD_RESET   = 9;

   // state codes shown in the state byte
   typedef enum logic [2:0] {
      ST_DISABLED  = 3'd0,
      ST_ENABLED   = 3'd1,
      ST_RUNNING   = 3'd2,
      ST_SUSPENDED = 3'd3,
      ST_STOPPED   = 3'd4
   } chan_st_e;

   typedef struct packed {
      logic dis;
      logic en;
      logic sus;
      logic rst;
   } cmd_hit_t;

endpackage

// File: rtl/chcmd_decode.sv
module chcmd_decode #(
   parameter int unsigned FIELD_W = 8
) (
   input  logic               wr,
   input  logic [FIELD_W-1:0] code,
   output chcmd_pkg::cmd_hit_t hit,
   output logic               known
);
   import chcmd_pkg::*;

   always_comb begin
      hit.dis = wr && (code == FIELD_W'(CMD_DISABLE));
      hit.en  = wr && (code == FIELD_W'(CMD_ENABLE));
      hit.sus = wr && (code == FIELD_W'(CMD_SUSPEND));
      hit.rst = wr && (code == FIELD_W'(CMD_RESET));
      known   = hit.dis | hit.en | hit.sus | hit.rst;
   end
endmodule

// File: rtl/chcmd_fsm.sv
module chcmd_fsm (
   input  logic                clk,
   input  logic                rst_n,
   input  chcmd_pkg::cmd_hit_t hit,
   input  logic                work_pend,
   input  logic                dp_idle,
   input  logic                dp_err,
   output chcmd_pkg::chan_st_e state,
   output logic                active,
   output logic                clr_pulse
);
   import chcmd_pkg::*;

   chan_st_e st_q, st_d;
   logic     drain_q, drain_d;
   logic     clr_q;

   wire oper = (st_q == ST_ENABLED) || (st_q == ST_RUNNING);

   always_comb begin
      st_d    = st_q;
      drain_d = drain_q;
      if (hit.rst) begin
         st_d    = ST_DISABLED;
         drain_d = 1'b0;
      end else if (st_q == ST_STOPPED) begin
         st_d = ST_STOPPED;
      end else if (st_q == ST_RUNNING && dp_err) begin
         st_d    = ST_STOPPED;
         drain_d = 1'b0;
      end else if (hit.dis) begin
         st_d    = ST_DISABLED;
         drain_d = 1'b0;
      end else if (hit.en) begin
         if (st_q == ST_DISABLED || st_q == ST_SUSPENDED) st_d = ST_ENABLED;
         drain_d = 1'b0;
      end else if (hit.sus) begin
         if (oper) begin
            if (dp_idle) begin
               st_d    = ST_SUSPENDED;
               drain_d = 1'b0;
            end else begin
               drain_d = 1'b1;
            end
         end
      end else if (drain_q) begin
         if (dp_idle) begin
            st_d    = ST_SUSPENDED;
            drain_d = 1'b0;
         end
      end else if (st_q == ST_ENABLED && work_pend) begin
         st_d = ST_RUNNING;
      end else if (st_q == ST_RUNNING && !work_pend && dp_idle) begin
         st_d = ST_ENABLED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_DISABLED;
         drain_q <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         drain_q <= drain_d;
         clr_q   <= hit.rst;
      end
   end

   assign state     = st_q;
   assign active    = oper && !drain_q;
   assign clr_pulse = clr_q;
endmodule

// File: rtl/chcmd_csr.sv
module chcmd_csr #(
   parameter int unsigned CSR_W     = 32,
   parameter int unsigned FIELD_W   = 8,
   parameter int unsigned CMD_LSB   = 16,
   parameter int unsigned STATE_LSB = 8,
   parameter bit          CMD_ECHO  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                known,
   input  logic [FIELD_W-1:0]  code,
   input  chcmd_pkg::chan_st_e state,
   output logic [CSR_W-1:0]    rdata
);
   logic [FIELD_W-1:0] echo;

   generate
      if (CMD_ECHO) begin : g_echo
         logic [FIELD_W-1:0] last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     last_q <= '0;
            else if (known) last_q <= code;
         end
         assign echo = last_q;
      end else begin : g_no_echo
         assign echo = '0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      rdata[STATE_LSB +: FIELD_W] = FIELD_W'(state);
      rdata[CMD_LSB   +: FIELD_W] = echo;
   end
endmodule

// File: rtl/chan_cmd_ctrl.sv
module chan_cmd_ctrl #(
   parameter int unsigned CSR_W     = 32,
   parameter int unsigned FIELD_W   = 8,
   parameter int unsigned CMD_LSB   = 16,
   parameter int unsigned STATE_LSB = 8,
   parameter bit          CMD_ECHO  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_we,
   input  logic [CSR_W-1:0] csr_wdata,
   output logic [CSR_W-1:0] csr_rdata,
   input  logic             work_pend,
   input  logic             dp_idle,
   input  logic             dp_err,
   output logic             chan_active,
   output logic             ptr_clr
);
   import chcmd_pkg::*;

   localparam int unsigned CMD_TOP   = CMD_LSB + FIELD_W;
   localparam int unsigned STATE_TOP = STATE_LSB + FIELD_W;

   generate
      if (FIELD_W < 4) begin : g_bad_width
         $error("FIELD_W too narrow for command codes");
      end
      if (CMD_TOP > CSR_W || STATE_TOP > CSR_W) begin : g_bad_fit
         $error("fields exceed CSR_W");
      end
      if (!(CMD_TOP <= STATE_LSB || STATE_TOP <= CMD_LSB)) begin : g_bad_overlap
         $error("command and state fields overlap");
      end
   endgenerate

   logic [FIELD_W-1:0] code;
   cmd_hit_t           hit;
   logic               known;
   chan_st_e           state;

   assign code = csr_wdata[CMD_LSB +: FIELD_W];

   chcmd_decode #(.FIELD_W(FIELD_W)) u_dec (
      .wr    (csr_we),
      .code  (code),
      .hit   (hit),
      .known (known)
   );

   chcmd_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .work_pend (work_pend),
      .dp_idle   (dp_idle),
      .dp_err    (dp_err),
      .state     (state),
      .active    (chan_active),
      .clr_pulse (ptr_clr)
   );

   chcmd_csr #(
      .CSR_W     (CSR_W),
      .FIELD_W   (FIELD_W),
      .CMD_LSB   (CMD_LSB),
      .STATE_LSB (STATE_LSB),
      .CMD_ECHO  (CMD_ECHO)
   ) u_csr (
      .clk   (clk),
      .rst_n (rst_n),
      .known (known),
      .code  (code),
      .state (state),
      .rdata (csr_rdata)
   );
endmodule

// File: rtl/chan_cmd_ctrl_chk.sv
module chan_cmd_ctrl_chk #(
   parameter int unsigned CSR_W     = 32,
   parameter int unsigned FIELD_W   = 8,
   parameter int unsigned CMD_LSB   = 16,
   parameter int unsigned STATE_LSB = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             csr_we,
   input logic [CSR_W-1:0] csr_wdata,
   input logic [CSR_W-1:0] csr_rdata,
   input logic             work_pend,
   input logic             dp_idle,
   input logic             dp_err,
   input logic             chan_active,
   input logic             ptr_clr
);
   import chcmd_pkg::*;

   wire [FIELD_W-1:0] st   = csr_rdata[STATE_LSB +: FIELD_W];
   wire [FIELD_W-1:0] echo = csr_rdata[CMD_LSB +: FIELD_W];
   wire [FIELD_W-1:0] wc   = csr_wdata[CMD_LSB +: FIELD_W];
   wire wr_rst   = csr_we && (wc == FIELD_W'(CMD_RESET));
   wire wr_undef = csr_we && !(wc == FIELD_W'(CMD_RESET)  || wc == FIELD_W'(CMD_ENABLE) ||
                               wc == FIELD_W'(CMD_DISABLE) || wc == FIELD_W'(CMD_SUSPEND));

   AST_ACTIVE_OPER: assert property (@(posedge clk) disable iff (!rst_n)
      chan_active |-> (st == FIELD_W'(1) || st == FIELD_W'(2))); // R3
   AST_RUN_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FIELD_W'(2) && $past(st) == FIELD_W'(1)) |-> $past(work_pend)); // R4
   AST_SUSP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FIELD_W'(3) && $past(st) != FIELD_W'(3)) |-> $past(dp_idle)); // R5
   AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FIELD_W'(4) && !wr_rst) |=> (st == FIELD_W'(4))); // R8
   AST_CLR_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst |=> (ptr_clr && st == FIELD_W'(0))); // R9
   AST_CLR_ONLY_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_rst |=> !ptr_clr); // R9
   AST_UNDEF_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_undef |=> $stable(echo)); // R10
endmodule

bind chan_cmd_ctrl chan_cmd_ctrl_chk #(
   .CSR_W(CSR_W), .FIELD_W(FIELD_W), .CMD_LSB(CMD_LSB), .STATE_LSB(STATE_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
   .csr_rdata(csr_rdata), .work_pend(work_pend), .dp_idle(dp_idle),
   .dp_err(dp_err), .chan_active(chan_active), .ptr_clr(ptr_clr)
);

// File: tb/test_chan_cmd_ctrl.sv
module test_chan_cmd_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        work_pend = 1'b0, dp_idle = 1'b1, dp_err = 1'b0;
   logic        chan_active, ptr_clr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // reference model
   int   m_st = 0;
   bit   m_drain = 1'b0, m_clr = 1'b0;
   logic [7:0] m_cmd = '0;

   always #10 clk = ~clk; // 50 MHz

   chan_cmd_ctrl i_chan_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .work_pend(work_pend), .dp_idle(dp_idle),
      .dp_err(dp_err), .chan_active(chan_active), .ptr_clr(ptr_clr)
   );

   function automatic logic [31:0] exp_rdata();
      return {8'h00, m_cmd, 8'(m_st), 8'h00};
   endfunction

   function automatic bit exp_active();
      return (m_st == 1 || m_st == 2) && !m_drain;
   endfunction

   task automatic model(input bit we, input logic [7:0] c, input bit wp, input bit id, input bit er);
      bit def = (c == 8'd0 || c == 8'd1 || c == 8'd2 || c == 8'd9);
      m_clr = we && c == 8'd9;
      if (we && c == 8'd9) begin
         m_st = 0; m_drain = 0;
      end else if (m_st == 4) begin
         m_st = 4;
      end else if (m_st == 2 && er) begin
         m_st = 4; m_drain = 0;
      end else if (we && def) begin
         if (c == 8'd0) begin
            m_st = 0; m_drain = 0;
         end else if (c == 8'd1) begin
            if (m_st == 0 || m_st == 3) m_st = 1;
            m_drain = 0;
         end else if (m_st == 1 || m_st == 2) begin
            if (id) begin m_st = 3; m_drain = 0; end
            else m_drain = 1;
         end
      end else if (m_drain) begin
         if (id) begin m_st = 3; m_drain = 0; end
      end else if (m_st == 1 && wp) begin
         m_st = 2;
      end else if (m_st == 2 && !wp && id) begin
         m_st = 1;
      end
      if (we && def) m_cmd = c;
   endtask

   task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check({tag, " rdata"}, csr_rdata === exp_rdata(), csr_rdata, exp_rdata());
      check({tag, " active"}, chan_active === exp_active(), 32'(chan_active), 32'(exp_active()));
      check({tag, " ptr_clr"}, ptr_clr === m_clr, 32'(ptr_clr), 32'(m_clr));
   endtask

   task automatic lit(input string tag, input int st, input bit act);
      check({tag, " state literal"}, csr_rdata[15:8] === 8'(st), 32'(csr_rdata[15:8]), 32'(st));
      check({tag, " active literal"}, chan_active === act, 32'(chan_active), 32'(act));
   endtask

   task automatic step(input string tag, input bit we, input logic [7:0] c,
                       input bit wp, input bit id, input bit er);
      csr_we = we;
      csr_wdata = $urandom;
      csr_wdata[23:16] = c;
      work_pend = wp; dp_idle = id; dp_err = er;
      @(posedge clk);
      model(we, c, wp, id, er);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      logic [7:0] codes [10] = '{8'd0, 8'd1, 8'd2, 8'd9, 8'd3, 8'd7, 8'hFF, 8'd1, 8'd2, 8'd1};
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      compare("R1");
      lit("R1", 0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      step("R3", 1, 8'd1, 0, 1, 0);  lit("R3", 1, 1);
      check("R2 echo", csr_rdata[23:16] === 8'd1, 32'(csr_rdata[23:16]), 32'd1);
      step("R4", 0, 8'd0, 1, 1, 0);  lit("R4", 2, 1);
      step("R4", 0, 8'd0, 1, 0, 0);  lit("R4", 2, 1);
      step("R4", 0, 8'd0, 0, 1, 0);  lit("R4", 1, 1);
      step("R4", 0, 8'd0, 1, 0, 0);
      step("R5", 1, 8'd2, 1, 0, 0);  lit("R5 drain", 2, 0);
      step("R5", 0, 8'd0, 0, 0, 0);  lit("R5 drain", 2, 0);
      step("R5", 0, 8'd0, 0, 1, 0);  lit("R5 done", 3, 0);
      step("R5", 1, 8'd2, 0, 1, 0);  lit("R5 again", 3, 0);
      step("R3", 1, 8'd1, 0, 1, 0);  lit("R3 resume", 1, 1);
      step("R6", 0, 8'd0, 1, 0, 0);
      step("R6", 1, 8'd2, 1, 0, 0);  lit("R6 drain", 2, 0);
      step("R6", 1, 8'd1, 1, 0, 0);  lit("R6 cancel", 2, 1);
      step("R6", 0, 8'd0, 0, 1, 0);  lit("R6", 1, 1);
      step("R10", 1, 8'd5, 0, 1, 0); lit("R10", 1, 1);
      check("R10 echo", csr_rdata[23:16] === 8'd1, 32'(csr_rdata[23:16]), 32'd1);
      step("R7", 1, 8'd0, 0, 1, 0);  lit("R7", 0, 0);
      step("R5", 1, 8'd2, 0, 1, 0);  lit("R5 from disabled", 0, 0);
      step("R8", 1, 8'd1, 0, 1, 0);
      step("R8", 0, 8'd0, 1, 0, 0);
      step("R8", 0, 8'd0, 1, 0, 1);  lit("R8 stop", 4, 0);
      step("R8", 1, 8'd1, 0, 1, 0);  lit("R8 sticky", 4, 0);
      step("R8", 1, 8'd0, 0, 1, 0);  lit("R8 sticky", 4, 0);
      step("R9", 1, 8'd9, 0, 1, 0);  lit("R9", 0, 0);
      check("R9 pulse", ptr_clr === 1'b1, 32'(ptr_clr), 32'd1);
      step("R9", 0, 8'd0, 0, 1, 0);
      check("R9 one cycle", ptr_clr === 1'b0, 32'(ptr_clr), 32'd0);
      step("R11", 1, 8'd1, 0, 1, 0);
      step("R11", 1, 8'd0, 1, 1, 0); lit("R11 cmd wins", 0, 0);
      step("R11", 1, 8'd1, 0, 1, 0);
      step("R11", 0, 8'd0, 1, 1, 0);
      step("R11", 1, 8'd0, 1, 0, 1); lit("R11 err wins", 4, 0);
      step("R9", 1, 8'd9, 0, 1, 0);

      for (int i = 0; i < 3000; i++) begin
         bit we = ($urandom % 100) < 30;
         logic [7:0] c = codes[$urandom % 10];
         if (c == 8'd9 && ($urandom % 4) != 0) c = 8'd1;
         step("R11 random", we, c, ($urandom % 2) == 0, ($urandom % 10) < 6,
              ($urandom % 100) < 4);
      end
      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule